// File: doc/BRIEF.md
# Synchronous Serial Byte Port

This block moves one byte at a time over a three-wire synchronous link (clock, data out, data in). Software configures it through a two-entry register port: a control register holding the clock rate, the clock idle level, the interrupt enable and a flag-clear strobe, and a data register that both starts a transfer and holds the received byte afterwards. When the `master_en` input is high the block produces the serial clock itself by dividing the system clock. When it is low, the block follows a clock that arrives on `sck_in`.

A write to the data register while the port is idle loads the byte and starts shifting, most significant bit first. Outgoing data changes on falling serial-clock edges and incoming data is sampled on rising edges, whatever the idle level. After the eighth sampling edge the received byte replaces the data register contents and the completion flag is raised. The flag drives `irq` when interrupts are enabled.

The controller has three states. IDLE holds the clock at its idle level and waits; a data write taken in IDLE moves it to XFER (transition *start*). XFER shifts the eight bits. On the eighth sampling edge it returns to IDLE (transition *finish*), unless the block is master with a low idle level. In that case it goes to TAIL (transition *park*), and TAIL drives one last falling edge half a period later before it returns to IDLE (transition *parked*).

Top module: `sync_serial_port`

## Requirements
- R1: After reset the control register reads 0x00, the data register reads 0x00, `sck_out` is high and `irq` is low.
- R2: In master mode the serial clock period, in system clocks, is set by control bits [1:0]: 00 gives 64, 01 gives 32, 10 gives 16 and 11 gives 8.
- R3: Control bit 2 selects the clock idle level. At 1 `sck_out` rests low between transfers; at 0 it rests high. The clock is back at the idle level once a transfer finishes.
- R4: Bits leave on `sdo` MSB first and change only on falling clock edges. `sdi` is sampled on rising clock edges. After completion the data register reads the eight sampled bits, first-sampled bit in bit 7.
- R5: The completion flag, read at control bit 7, is set by the eighth rising edge of a transfer.
- R6: Writing the control register with bit 5 at 1 clears the completion flag. Writing it with bit 5 at 0 leaves the flag unchanged. Bit 5 always reads 0.
- R7: `irq` is high exactly when the completion flag and the interrupt enable (control bit 4) are both 1.
- R8: `sck_oe` follows `master_en`. In slave mode the shifter runs on `sck_in` edges, and `sck_out` does not toggle because the divider is held.
- R9: A write to the data register while a transfer is in progress is ignored. The bits shifted out and the byte received are unchanged.
- R10: Address 0 selects the control register and address 1 the data register. Control bits 0, 1, 2 and 4 read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| master_en | input | 1 | 1: block drives the serial clock; 0: follows `sck_in` |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock generated in master mode |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume the following about the inputs. `master_en` and the control fields are held steady while a transfer runs. An external `sck_in` keeps each phase several system clocks long, so the two-stage synchronizer never misses an edge. `sdi` only moves while the clock is low, away from the sampling edge. The bench keeps to these limits. It rewrites the control register only between transfers, drives `sck_in` with eight-cycle half periods, and changes `sdi` only on the falling edges it detects or generates itself.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_TAIL = 2'd2
    } ssp_state_e;

    localparam int unsigned CTRL_RATE_LSB = 0;
    localparam int unsigned CTRL_IDLE_LOW = 2;
    localparam int unsigned CTRL_IRQ_EN   = 4;
    localparam int unsigned CTRL_CLR      = 5;
    localparam int unsigned CTRL_FLAG     = 7;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

endpackage

// File: rtl/ssp_clkdiv.sv
module ssp_clkdiv #(
    parameter int unsigned BASE_HALF = 4,
    parameter int unsigned RATE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int unsigned MAX_SEL  = (1 << RATE_W) - 1;
    localparam int unsigned MAX_HALF = BASE_HALF << MAX_SEL;
    localparam int unsigned CW       = $clog2(MAX_HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_v;

    // highest code selects the shortest half period
    always_comb begin
        last_v = CW'((BASE_HALF << (MAX_SEL - 32'(rate))) - 1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q == last_v) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == last_v);

    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_start_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic              sdo,
    output logic              done,
    output logic [DATA_W-1:0] rx_data
);
    localparam int unsigned CNTW = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] sh_q;
    logic [CNTW-1:0]   cnt_q;
    logic              samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            samp_q <= 1'b0;
        end else if (load) begin
            sh_q  <= load_data;
            cnt_q <= '0;
        end else if (rise) begin
            samp_q <= sdi;
            cnt_q  <= cnt_q + 1'b1;
        end else if (fall) begin
            // a falling edge before the first sample or after the last does not shift
            if (cnt_q != '0 && cnt_q != CNTW'(DATA_W)) begin
                sh_q <= {sh_q[DATA_W-2:0], samp_q};
            end
        end
    end

    assign sdo     = sh_q[DATA_W-1];
    assign done    = rise && (cnt_q == CNTW'(DATA_W - 1));
    assign rx_data = {sh_q[DATA_W-2:0], sdi};

    assert_edge_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

    assert_bit_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DATA_W));

    assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rise) && !$past(load)) |-> $stable(sdo));

endmodule

// File: rtl/ssp_fsm.sv
module ssp_fsm
    import ssp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic master,
    input  logic idle_low,
    input  logic tick,
    input  logic done,
    input  logic sck_in,
    output logic div_run,
    output logic rise,
    output logic fall,
    output logic sck_level,
    output logic busy
);
    ssp_state_e state_q, state_d;
    logic       sck_q;
    logic [2:0] sync_q;
    logic       ext_rise, ext_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sck_in};
        end
    end

    assign ext_rise = sync_q[1] && !sync_q[2];
    assign ext_fall = !sync_q[1] && sync_q[2];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_XFER;
            ST_XFER: if (done)  state_d = (master && idle_low) ? ST_TAIL : ST_IDLE;
            ST_TAIL: if (tick)  state_d = ST_IDLE;
            default:            state_d = ST_IDLE;
        endcase
    end

    // generated clock level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b1;
        end else if (state_q == ST_IDLE) begin
            sck_q <= !idle_low;
        end else if (tick) begin
            sck_q <= !sck_q;
        end
    end

    // outputs
    always_comb begin
        div_run = 1'b0;
        rise    = 1'b0;
        fall    = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: busy = 1'b0;
            ST_XFER: begin
                div_run = master;
                if (master) begin
                    rise = tick && !sck_q;
                    fall = tick &&  sck_q;
                end else begin
                    rise = ext_rise;
                    fall = ext_fall;
                end
            end
            ST_TAIL: div_run = master;
            default: busy = 1'b0;
        endcase
    end

    assign sck_level = sck_q;

    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_q == ST_IDLE) |-> (sck_q == !$past(idle_low)));

    assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q != ST_IDLE) && !master && $past(!master))
            |-> $stable(sck_q));

    assert_tail_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL && tick) |=> (state_q == ST_IDLE && !sck_q));

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned RATE_W    = 2,
    parameter int unsigned BASE_HALF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              master_en,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    output logic              sdo,
    input  logic              sdi,
    output logic              irq
);
    logic [RATE_W-1:0] rate_q;
    logic              idle_low_q;
    logic              irq_en_q;
    logic              flag_q;
    logic [DATA_W-1:0] data_q;

    logic              wr_ctrl, wr_data, start;
    logic              busy, div_run, tick, rise, fall, done;
    logic [DATA_W-1:0] rx_data;
    logic [DATA_W-1:0] ctrl_img;
    logic              wdata_unused;

    assign wr_ctrl      = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_data      = bus_wr && (bus_addr == ADDR_DATA);
    assign start        = wr_data && !busy;
    assign wdata_unused = ^bus_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q     <= '0;
            idle_low_q <= 1'b0;
            irq_en_q   <= 1'b0;
        end else if (wr_ctrl) begin
            rate_q     <= bus_wdata[CTRL_RATE_LSB +: RATE_W];
            idle_low_q <= bus_wdata[CTRL_IDLE_LOW];
            irq_en_q   <= bus_wdata[CTRL_IRQ_EN];
        end
    end

    // completion wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (done) begin
            flag_q <= 1'b1;
        end else if (wr_ctrl && bus_wdata[CTRL_CLR]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (done) begin
            data_q <= rx_data;
        end else if (start) begin
            data_q <= bus_wdata;
        end
    end

    always_comb begin
        ctrl_img                               = '0;
        ctrl_img[CTRL_RATE_LSB +: RATE_W]      = rate_q;
        ctrl_img[CTRL_IDLE_LOW]                = idle_low_q;
        ctrl_img[CTRL_IRQ_EN]                  = irq_en_q;
        ctrl_img[CTRL_FLAG]                    = flag_q;
        bus_rdata = (bus_addr == ADDR_DATA) ? data_q : ctrl_img;
    end

    ssp_clkdiv #(
        .BASE_HALF (BASE_HALF),
        .RATE_W    (RATE_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .rate  (rate_q),
        .tick  (tick)
    );

    ssp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .master    (master_en),
        .idle_low  (idle_low_q),
        .tick      (tick),
        .done      (done),
        .sck_in    (sck_in),
        .div_run   (div_run),
        .rise      (rise),
        .fall      (fall),
        .sck_level (sck_out),
        .busy      (busy)
    );

    ssp_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (bus_wdata),
        .rise      (rise),
        .fall      (fall),
        .sdi       (sdi),
        .sdo       (sdo),
        .done      (done),
        .rx_data   (rx_data)
    );

    assign sck_oe = master_en;
    assign irq    = flag_q && irq_en_q;

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> flag_q);

    assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CTRL_CLR] && !done) |=> !flag_q);

    assert_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_data && !done) |=> $stable(data_q));

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !done) |=> !irq || $past(wr_ctrl) == 1'b0 && !irq);

endmodule

// File: tb/sync_serial_port_tb.sv
module sync_serial_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       master_en = 1'b1;
    logic       sck_in = 1'b1;
    logic       sck_out, sck_oe, sdo, irq;
    logic       sdi = 1'b0;

    always #2 clk = ~clk;

    sync_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .master_en (master_en),
        .sck_in    (sck_in),
        .sck_out   (sck_out),
        .sck_oe    (sck_oe),
        .sdo       (sdo),
        .sdi       (sdi),
        .irq       (irq)
    );

    typedef struct packed {
        logic [7:0] tx;
        logic [7:0] rx;
    } item_t;

    item_t      sb_q[$];
    int         n_cmp = 0;
    int         n_bad = 0;

    // bench-side serial partner
    bit         m_act = 1'b0;
    bit         s_act = 1'b0;
    logic [7:0] slv_byte = 8'h00;
    logic [7:0] cap = 8'h00;
    int         nbits = 0;
    int         idx = 0;
    int         cyc = 0;
    int         last_rise = -1;
    int         period = 0;
    int         s_toggles = 0;
    logic       prev_sck = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    always @(negedge clk) begin
        cyc++;
        if (m_act) begin
            if (sck_out && !prev_sck) begin
                cap = {cap[6:0], sdo};
                nbits++;
                if (period == 0 && last_rise >= 0) period = cyc - last_rise;
                last_rise = cyc;
            end else if (!sck_out && prev_sck) begin
                if (nbits > 0 && nbits < 8) begin
                    idx++;
                    sdi = slv_byte[7-idx];
                end
            end
        end
        if (s_act && (sck_out != prev_sck)) s_toggles++;
        prev_sck = sck_out;
    end

    // scoreboard monitor: one expected item per completion
    initial begin
        item_t it;
        forever begin
            @(posedge irq);
            repeat (2) @(negedge clk);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R5", "unexpected completion", 1, 0);
            end else begin
                it = sb_q.pop_front();
                chk(cap == it.tx, "R4", "sdo byte MSB first", cap, it.tx);
            end
        end
    end

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx,
                               input logic [1:0] rate, input logic idle_low,
                               input bit inject);
        logic [7:0] r;
        item_t it;
        master_en = 1'b1;
        wr(1'b0, 8'h30 | {5'b0, idle_low, rate});
        repeat (2) @(negedge clk);
        chk(sck_out == !idle_low, "R3", "idle level before transfer", sck_out, !idle_low);
        slv_byte = rx; idx = 0; nbits = 0; cap = 8'h00;
        last_rise = -1; period = 0; sdi = rx[7];
        m_act = 1'b1;
        it.tx = tx; it.rx = rx;
        sb_q.push_back(it);
        wr(1'b1, tx);
        if (inject) begin
            repeat (20) @(negedge clk);
            wr(1'b1, 8'hFF);
        end
        while (!irq) @(negedge clk);
        repeat (80) @(negedge clk);
        m_act = 1'b0;
        rd(1'b1, r);
        chk(r == rx, inject ? "R9" : "R4", "received byte", r, rx);
        chk(period == (64 >> rate), "R2", "sck period", period, 64 >> rate);
        chk(sck_out == !idle_low, "R3", "idle level after transfer", sck_out, !idle_low);
        chk(nbits == 8, "R4", "rising edge count", nbits, 8);
        rd(1'b0, r);
        chk(r[7] == 1'b1, "R5", "flag after transfer", r[7], 1);
    endtask

    task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rx,
                              input logic idle_low);
        logic [7:0] r;
        item_t it;
        master_en = 1'b0;
        sck_in = !idle_low;
        wr(1'b0, 8'h30 | {5'b0, idle_low, 2'b00});
        repeat (4) @(negedge clk);
        chk(sck_oe == 1'b0, "R8", "sck_oe in slave mode", sck_oe, 0);
        cap = 8'h00; sdi = rx[7]; s_toggles = 0;
        s_act = 1'b1;
        it.tx = tx; it.rx = rx;
        sb_q.push_back(it);
        wr(1'b1, tx);
        repeat (4) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            if (!idle_low) begin
                sck_in = 1'b0;
                if (i > 0) sdi = rx[7-i];
                repeat (8) @(negedge clk);
                cap = {cap[6:0], sdo};
                sck_in = 1'b1;
                repeat (8) @(negedge clk);
            end else begin
                cap = {cap[6:0], sdo};
                sck_in = 1'b1;
                repeat (8) @(negedge clk);
                sck_in = 1'b0;
                if (i < 7) sdi = rx[6-i];
                repeat (8) @(negedge clk);
            end
        end
        repeat (8) @(negedge clk);
        s_act = 1'b0;
        rd(1'b1, r);
        chk(r == rx, "R8", "slave received byte", r, rx);
        chk(s_toggles == 0, "R8", "sck_out toggles in slave mode", s_toggles, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, r);
        chk(r == 8'h00, "R1", "control after reset", r, 8'h00);
        rd(1'b1, r);
        chk(r == 8'h00, "R1", "data after reset", r, 8'h00);
        chk(sck_out == 1'b1, "R1", "sck_out after reset", sck_out, 1);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(sck_oe == 1'b1, "R8", "sck_oe in master mode", sck_oe, 1);

        wr(1'b0, 8'h17);
        rd(1'b0, r);
        chk(r == 8'h17, "R10", "control readback", r, 8'h17);

        master_xfer(8'hA5, 8'h3C, 2'b00, 1'b0, 1'b0);
        master_xfer(8'h81, 8'hF0, 2'b01, 1'b1, 1'b0);
        master_xfer(8'h5A, 8'h01, 2'b10, 1'b0, 1'b0);
        master_xfer(8'hC3, 8'h7E, 2'b11, 1'b1, 1'b1);

        chk(irq == 1'b1, "R7", "irq with flag and enable", irq, 1);
        wr(1'b0, 8'h07);
        rd(1'b0, r);
        chk(r[7] == 1'b1, "R6", "flag kept by clear bit 0", r[7], 1);
        chk(r[5] == 1'b0, "R6", "clear bit reads 0", r[5], 0);
        chk(irq == 1'b0, "R7", "irq masked by enable", irq, 0);
        wr(1'b0, 8'h27);
        rd(1'b0, r);
        chk(r[7] == 1'b0, "R6", "flag cleared by clear bit 1", r[7], 0);
        chk(r[5] == 1'b0, "R6", "clear bit reads 0 after write", r[5], 0);

        slave_xfer(8'h96, 8'h69, 1'b0);
        slave_xfer(8'h0F, 8'hB2, 1'b1);

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R5", "all transfers completed", sb_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule